// File: doc/BRIEF.md
# ODT Window Timing Calculator

This block works out when the on-die termination of a memory interface should switch on and off around a read burst. A start pulse hands it a 32-bit word that packs four per-chip-select read-sample delays. The block walks the chip-selects in ascending order and keeps the smallest and the largest delay. For every chip-select whose delay is not below the largest seen so far, it fetches the read-leveling phase register of each byte lane. These fetches go one lane at a time over a valid/ready port.

When the walk ends, the block derives the window start from the smallest delay and the window end from the largest delay plus the leveling phase. It clamps both values to their field widths and places them in a timing register image. It then raises a one-cycle done pulse. The outputs hold their values until the next computation finishes. The block does only the sequencing and the arithmetic. The register bus, the PHY and the memory device lie outside it.

Top module: `odt_window_calc`

## Requirements
- R1: The 4-bit read-sample delay of chip-select n (n = 0..3) is taken from bits [8n+3:8n] of `sample_word`, captured in the cycle `start` is accepted. The other bits of the word, and any later change of the word, have no effect.
- R2: Chip-selects are visited in order 0, 1, 2, 3. A chip-select is fetched only when its delay is greater than or equal to the largest delay among the earlier chip-selects, with that largest value starting at 0. A fetched chip-select issues one request per lane, lanes 0 to LANES-1 in ascending order. No other request is issued.
- R3: The phase of a lane is `fetch_data[7:6]` as an unsigned value 0..3. Bits [5:0] are ignored.
- R4: The running phase maximum is cleared to "none" when a fetched chip-select's delay equals the running largest delay. A strictly larger delay keeps the phases gathered so far. Each fetched lane raises the maximum when its phase is greater than or equal to it.
- R5: `odt_end` = largest delay + 4 + (phase maximum + 1)/2 (integer division) + 1, saturated at 31.
- R6: `odt_start` = smallest delay − 1, saturated at 0. The smallest delay starts at 15, so the result never exceeds 15.
- R7: `odt_image` carries `odt_start` in bits [15:12] and `odt_end` in bits [20:16]. All other bits are zero.
- R8: `done` is high for exactly one cycle per accepted start. With `fetch_ready` held high, `done` is seen L clock edges after the edge that accepts `start`, counting that edge as 1. L = 2 + Σ over chip-selects of (1 + LANES if fetched, else 1). The outputs stay unchanged between done pulses.
- R9: A `start` pulse that arrives while a computation is in progress is ignored. It neither changes the result nor produces an extra done pulse.
- R10: While `fetch_valid` is high and `fetch_ready` is low, the request holds, with `fetch_cs` and `fetch_lane` unchanged.
- R11: After reset, `done` and `fetch_valid` are 0 and `odt_start`, `odt_end` and `odt_image` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (ignored when busy) |
| sample_word | input | 32 | Packed read-sample delays, 8 bits per chip-select |
| fetch_valid | output | 1 | Phase register request valid |
| fetch_cs | output | 2 | Chip-select of the requested register |
| fetch_lane | output | LANE_W | Byte lane of the requested register |
| fetch_ready | input | 1 | Request accepted, `fetch_data` valid this cycle |
| fetch_data | input | 8 | Leveling register contents, phase in [7:6] |
| done | output | 1 | One-cycle completion pulse |
| odt_start | output | 4 | Window start value |
| odt_end | output | 5 | Window end value |
| odt_image | output | 32 | Timing register image with both fields placed |

## Verification
Each pattern of delays has a specific job:
- Equal delays on all chip-selects show the phase-maximum reset, because a high phase on chip-select 0 must not reach the result.
- Rising delays show that phases are kept across chip-selects.
- Falling delays show that later chip-selects are skipped and that no request is made for them.
- All-zero and all-fifteen words reach the start saturation and the largest end value.

Garbage in unused word bits and in the low bits of the fetched data shows that only the named fields are read. Random words with a stalling ready test the request hold and the lane order under back-pressure. A second start injected mid-run shows that it is ignored.

// File: rtl/odt_window_calc.sv
module odt_window_calc #(
  parameter int LANES = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       sample_word,
  output logic              fetch_valid,
  output logic [1:0]        fetch_cs,
  output logic [LANE_W-1:0] fetch_lane,
  input  logic              fetch_ready,
  input  logic [7:0]        fetch_data,
  output logic              done,
  output logic [3:0]        odt_start,
  output logic [4:0]        odt_end,
  output logic [31:0]       odt_image
);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_FETCH, S_FIN} st_t;

  st_t               st;
  logic [31:0]       word_q;
  logic [1:0]        cs_q;
  logic [LANE_W-1:0] lane_q;
  logic [3:0]        max_q, min_q;
  logic [1:0]        ph_q;
  logic              ph_v;

  logic [3:0] dly;
  logic       xfer, last_cs, last_lane;
  logic [1:0] ph_in;
  logic [2:0] ph_inc;
  logic [5:0] end_raw;
  logic [4:0] end_sat;
  logic [3:0] start_sat;
  logic       unused_bits;

  assign dly       = word_q[{cs_q, 3'b000} +: 4];
  assign xfer      = fetch_valid && fetch_ready;
  assign ph_in     = fetch_data[7:6];
  assign last_cs   = &cs_q;
  assign last_lane = lane_q == LANE_W'(LANES - 1);
  assign ph_inc    = {1'b0, ph_q} + 3'd1;
  assign end_raw   = {2'b00, max_q} + 6'd5 + {4'b0000, ph_inc[2:1]};
  assign end_sat   = (end_raw > 6'd31) ? 5'd31 : end_raw[4:0];
  assign start_sat = (min_q == 4'd0) ? 4'd0 : min_q - 4'd1;
  assign unused_bits = &{1'b0, fetch_data[5:0]};

  assign fetch_valid = st == S_FETCH;
  assign fetch_cs    = cs_q;
  assign fetch_lane  = lane_q;
  assign odt_image   = {11'b0, odt_end, odt_start, 12'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      word_q    <= '0;
      cs_q      <= '0;
      lane_q    <= '0;
      max_q     <= '0;
      min_q     <= 4'hF;
      ph_q      <= '0;
      ph_v      <= 1'b0;
      done      <= 1'b0;
      odt_start <= '0;
      odt_end   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          word_q <= sample_word;
          cs_q   <= '0;
          max_q  <= '0;
          min_q  <= 4'hF;
          ph_v   <= 1'b0;
          st     <= S_EVAL;
        end
        S_EVAL: begin
          if (dly < min_q) min_q <= dly;
          if (dly >= max_q) begin
            if (dly == max_q) ph_v <= 1'b0;
            max_q  <= dly;
            lane_q <= '0;
            st     <= S_FETCH;
          end else if (last_cs) begin
            st <= S_FIN;
          end else begin
            cs_q <= cs_q + 2'd1;
          end
        end
        S_FETCH: if (xfer) begin
          if (!ph_v || ph_in >= ph_q) begin
            ph_q <= ph_in;
            ph_v <= 1'b1;
          end
          if (last_lane) begin
            if (last_cs) begin
              st <= S_FIN;
            end else begin
              cs_q <= cs_q + 2'd1;
              st   <= S_EVAL;
            end
          end else begin
            lane_q <= lane_q + LANE_W'(1);
          end
        end
        default: begin
          odt_start <= start_sat;
          odt_end   <= end_sat;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/odt_window_calc_chk.sv
module odt_window_calc_chk #(
  parameter int LANES = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [31:0]       sample_word,
  input logic              fetch_valid,
  input logic [1:0]        fetch_cs,
  input logic [LANE_W-1:0] fetch_lane,
  input logic              fetch_ready,
  input logic [7:0]        fetch_data,
  input logic              done,
  input logic [3:0]        odt_start,
  input logic [4:0]        odt_end,
  input logic [31:0]       odt_image
);

  logic unused_chk;
  assign unused_chk = &{1'b0, start, sample_word, fetch_data};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(odt_image)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_cs) && $stable(fetch_lane))); // R10

  AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (int'(fetch_lane) < LANES)); // R2

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fetch_valid); // R2

  AST_END_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (odt_end >= 5'd5)); // R5

  AST_START_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    odt_start <= 4'd14); // R6

endmodule

bind odt_window_calc odt_window_calc_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sample_word(sample_word),
  .fetch_valid(fetch_valid), .fetch_cs(fetch_cs), .fetch_lane(fetch_lane),
  .fetch_ready(fetch_ready), .fetch_data(fetch_data), .done(done),
  .odt_start(odt_start), .odt_end(odt_end), .odt_image(odt_image)
);

// File: tb/odt_window_calc_bench.sv
module odt_window_calc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int LANE_W = $clog2(LANES);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       sample_word = '0;
  logic              fetch_valid;
  logic [1:0]        fetch_cs;
  logic [LANE_W-1:0] fetch_lane;
  logic              fetch_ready;
  logic [7:0]        fetch_data;
  logic              done;
  logic [3:0]        odt_start;
  logic [4:0]        odt_end;
  logic [31:0]       odt_image;

  odt_window_calc #(.LANES(LANES)) u_odt_window_calc (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, done_cnt = 0;
  logic [1:0] ph_tab [4][LANES];
  int   gseed = 0;
  logic stall = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  int   expq[$];
  logic [31:0] exp_img = '0, held_img = '0;
  int   exp_s = 0, exp_e = 0, exp_lat = 0;
  bit   ended = 0;

  always_ff @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign fetch_ready = !stall || lfsr[0];
  always_comb fetch_data = {ph_tab[fetch_cs][fetch_lane], 6'((int'(fetch_cs) * 37 + int'(fetch_lane) * 11 + gseed) & 63)};

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural reference: expected requests, result and latency
  task automatic build(input logic [31:0] w);
    int mx, mn, ph, d, e, s;
    mx = 0; mn = 15; ph = -1; exp_lat = 2;
    expq.delete();
    for (int c = 0; c < 4; c++) begin
      d = (w >> (8 * c)) & 15;
      exp_lat += 1;
      if (d < mn) mn = d;
      if (d >= mx) begin
        if (d == mx) ph = -1;
        mx = d;
        exp_lat += LANES;
        for (int l = 0; l < LANES; l++) begin
          expq.push_back(c * 16 + l);
          if (int'(ph_tab[c][l]) >= ph) ph = int'(ph_tab[c][l]);
        end
      end
    end
    e = mx + 4 + (ph + 1) / 2 + 1;
    if (e > 31) e = 31;
    s = (mn > 0) ? mn - 1 : 0;
    exp_s = s; exp_e = e;
    exp_img = (32'(e) << 16) | (32'(s) << 12);
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_n && !ended) begin
    if (fetch_valid && fetch_ready) begin
      if (expq.size() == 0) chk(0, "R2 unexpected request", int'(fetch_cs) * 16 + int'(fetch_lane), -1);
      else begin
        chk(int'(fetch_cs) * 16 + int'(fetch_lane) == expq[0], "R2 request order cs*16+lane",
            int'(fetch_cs) * 16 + int'(fetch_lane), expq[0]);
        void'(expq.pop_front());
      end
    end
    if (done) begin
      done_cnt++;
      chk(odt_image == exp_img, "R7 image", int'(odt_image), int'(exp_img));
      chk(expq.size() == 0, "R2 missing requests", expq.size(), 0);
      held_img = odt_image;
    end else if (odt_image !== held_img) begin
      chk(0, "R8 result not stable", int'(odt_image), int'(held_img));
    end
  end

  task automatic run_case(input logic [31:0] w, input bit stl, input bit inject);
    int k, dc0;
    build(w);
    dc0 = done_cnt;
    @(negedge clk);
    stall = stl; start = 1'b1; sample_word = w;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = (inject && k == 3);
      if (k == 2) sample_word = ~w;
    end while (!done && k < 400);
    start = 1'b0;
    chk(done == 1'b1, "R8 done seen", int'(done), 1);
    if (!stl) chk(k == exp_lat, "R8 latency", k, exp_lat);
    chk(int'(odt_start) == exp_s, "R6 start", int'(odt_start), exp_s);
    chk(int'(odt_end) == exp_e, "R5 end", int'(odt_end), exp_e);
    repeat (8) @(negedge clk);
    chk(done_cnt == dc0 + 1, "R9 one done per accepted start", done_cnt - dc0, 1);
  endtask

  task automatic fill_ph(input int c0, input int v);
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < LANES; l++)
        ph_tab[c][l] = 2'((c * 3 + l * 5 + v + c0) % 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int c = 0; c < 4; c++) for (int l = 0; l < LANES; l++) ph_tab[c][l] = 2'd0;
    repeat (3) @(negedge clk);
    chk(done == 0 && fetch_valid == 0, "R11 reset controls", int'(done) + int'(fetch_valid), 0);
    chk(odt_image == 0 && odt_start == 0 && odt_end == 0, "R11 reset result", int'(odt_image), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: equal delays, high phase only on cs0 must be dropped; R1 garbage in upper bits
    ph_tab[0][2] = 2'd3; ph_tab[3][1] = 2'd1;
    gseed = 5;
    run_case(32'hF5A5_C5B5, 0, 0);
    // R4: rising delays keep the earlier phase
    run_case(32'h0403_0201, 0, 0);
    // R2: falling delays fetch only cs0, R6 start from minimum 3
    run_case(32'h0305_0709, 0, 0);
    // R6: all zero saturates start at 0
    run_case(32'h0000_0000, 0, 0);
    // R5: all fifteen with phase 3 gives the largest end; R3 garbage low bits
    for (int c = 0; c < 4; c++) for (int l = 0; l < LANES; l++) ph_tab[c][l] = 2'd3;
    gseed = 63;
    run_case(32'h0F0F_0F0F, 0, 0);
    // R10: stalling ready
    fill_ph(1, 2);
    run_case(32'h0206_0604, 1, 0);
    // R9: second start mid-run ignored
    fill_ph(0, 1);
    run_case(32'h0102_0708, 0, 1);
    // R3: phase bits only, lane order under random patterns
    for (int i = 0; i < 8; i++) begin
      fill_ph(i, int'($urandom_range(0, 3)));
      gseed = int'($urandom_range(0, 63));
      run_case($urandom, bit'(i % 2), bit'(i == 5));
    end
    summary();
  end
endmodule